// File: doc/BRIEF.md
# SPI Word FIFO and Interrupt Unit

This block sits between a register bus and the serial engine of an SPI controller. It buffers outgoing words in an eight-entry transmit queue and incoming words in an eight-entry receive queue, both 32 bits wide. Software pushes transmit words and pops receive words through one shared data address. The engine takes transmit words from a valid/take stream and delivers receive words through a single-cycle strobe.

Programmable levels on each queue raise event flags: one when the receive queue climbs to its level, one when the transmit queue drains down to its level. A third flag marks a receive word lost to a full queue. Each flag is gated by an enable bit, and the gated flags are ORed into one interrupt line. Software reads the flags and clears them with write-one-to-clear at the same address. Each queue can be emptied at once by a self-clearing flush bit.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: After reset both queues are empty, every register reads zero, `tx_valid` is 0 and `irq` is 0.
- R2: A write to the data offset (0x10) appends to the transmit queue unless it holds 8 words; then the write is ignored. `tx_valid` is high while the queue is not empty, `tx_word` shows the oldest word, and `tx_take` removes it.
- R3: A read of the data offset returns the oldest receive word and removes it. A read while the receive queue is empty returns 0 and leaves both levels unchanged.
- R4: In the control register (0x0C), bit 12 flushes the transmit queue and bit 4 flushes the receive queue. Each takes effect at the clock edge of the write and always reads back as 0. A flush wins over a push in the same cycle. Bits 11:8 hold the transmit level and bits 3:0 the receive level; both read back.
- R5: The status register (0x04) shows receive-not-empty at bit 0, the transmit level at bits 11:8 and the receive level at bits 19:16.
- R6: When `rx_valid` arrives while the receive queue holds 8 words and no data read happens in that cycle, the word is dropped and the overrun flag (bit 0 of 0x08) sets. A data read in the same cycle makes room, and no overrun occurs.
- R7: The receive-complete flag (bit 3 of 0x08) sets when an engine word raises the receive level from below a nonzero receive threshold to reach it. Bit 9 of 0x08 reads 1 exactly while the threshold is nonzero and the level is at least the threshold.
- R8: The transmit-complete flag (bit 4 of 0x08) sets when an engine take, with no push in the same cycle, lowers the transmit level from one above the transmit threshold down to it.
- R9: Writing 1 to bit 0, 3 or 4 of 0x08 clears that flag. A set in the same cycle takes priority over the clear.
- R10: The enable register (0x00) holds enables at bits 0, 3 and 4, one for each flag at the same bit position. `irq` is high exactly when some flag and its enable are both 1.
- R11: `reg_rdata` loads the addressed value at the clock edge where `reg_rd_en` is high and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request |
| tx_word | output | 32 | Oldest transmit word |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_take | input | 1 | Engine consumes `tx_word` |
| rx_word | input | 32 | Word from the engine |
| rx_valid | input | 1 | Strobe for `rx_word` |

## Verification
The hardest cases are the ones where two sides act on the same queue in the same cycle. One is a word from the engine meeting a software pop while the receive queue is full. Another is a flush write meeting a push. A third is a threshold crossing, which must set its flag once and not again while the level stays there. The stimulus first fills the receive queue to exactly eight words, then issues a data read together with an engine strobe. It also pairs a flush with a push in one operation. It walks the transmit level down past the threshold one take at a time, checking `irq` after every step. A behavioural queue model is compared with the outputs on every clock.

// File: rtl/spi_fic_pkg.sv
package spi_fic_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned THR_W  = 4;

  // byte offsets
  localparam logic [7:0] OFF_IE    = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_ISTAT = 8'h08;
  localparam logic [7:0] OFF_CTRL  = 8'h0C;
  localparam logic [7:0] OFF_DATA  = 8'h10;

  // bit positions decoded by software
  localparam int unsigned B_OVR    = 0;
  localparam int unsigned B_RCMP   = 3;
  localparam int unsigned B_TCMP   = 4;
  localparam int unsigned B_RRDY   = 9;
  localparam int unsigned B_RXFL   = 4;
  localparam int unsigned B_TXFL   = 12;
  localparam int unsigned B_RXTHR  = 0;
  localparam int unsigned B_TXTHR  = 8;
  localparam int unsigned B_RXNE   = 0;
  localparam int unsigned B_TXLVL  = 8;
  localparam int unsigned B_RXLVL  = 16;

  // flag vector index: 0 overrun, 1 receive complete, 2 transmit complete
  localparam int unsigned N_FLAG = 3;
  typedef logic [N_FLAG-1:0] flag_vec_t;
endpackage

// File: rtl/spi_fic_fifo.sv
module spi_fic_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] head_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             push_acc_o,
  output logic             pop_acc_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             upd_en;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o    = (lvl_q == '0);
  assign full_o     = (lvl_q == LVL_W'(DEPTH));
  assign pop_acc_o  = pop_i && !empty_o;
  assign push_acc_o = push_i && (!full_o || pop_acc_o);
  assign upd_en     = flush_i || push_acc_o || pop_acc_o;
  assign level_o    = lvl_q;
  assign head_o     = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (push_acc_o) wr_d = ptr_inc(wr_q);
      if (pop_acc_o)  rd_d = ptr_inc(rd_q);
      if (push_acc_o && !pop_acc_o)      lvl_d = lvl_q + 1'b1;
      else if (pop_acc_o && !push_acc_o) lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (upd_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc_o && !flush_i) mem_q[wr_q] <= wdata_i;
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= LVL_W'(DEPTH));
  assert_flush_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> empty_o);
  assert_full_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o);
endmodule

// File: rtl/spi_fic_irq.sv
module spi_fic_irq
  import spi_fic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_i,
  input  logic      clr_en_i,
  input  flag_vec_t clr_mask_i,
  input  flag_vec_t en_i,
  output flag_vec_t flags_o,
  output logic      irq_o
);
  flag_vec_t flags_q;

  for (genvar g = 0; g < N_FLAG; g++) begin : g_flag
    logic flag_d;
    logic flag_en;

    assign flag_en = set_i[g] || (clr_en_i && clr_mask_i[g]);

    always_comb begin
      flag_d = flags_q[g];
      if (clr_en_i && clr_mask_i[g]) flag_d = 1'b0;
      if (set_i[g])                  flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags_q[g] <= 1'b0;
      else if (flag_en) flags_q[g] <= flag_d;
    end

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en_i && clr_mask_i[g] && !set_i[g]) |=> !flags_q[g]);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flags_q[g]);
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |-> !irq_o);
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
  import spi_fic_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic [31:0]       tx_word,
  output logic              tx_valid,
  input  logic              tx_take,
  input  logic [31:0]       rx_word,
  input  logic              rx_valid
);
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);
  localparam int unsigned CMP_W = ((LVL_W > THR_W) ? LVL_W : THR_W) + 1;

  // decode
  logic sel_ie, sel_stat, sel_istat, sel_ctrl, sel_data;
  assign sel_ie    = (reg_addr == ADDR_W'(OFF_IE));
  assign sel_stat  = (reg_addr == ADDR_W'(OFF_STAT));
  assign sel_istat = (reg_addr == ADDR_W'(OFF_ISTAT));
  assign sel_ctrl  = (reg_addr == ADDR_W'(OFF_CTRL));
  assign sel_data  = (reg_addr == ADDR_W'(OFF_DATA));

  logic tx_flush, rx_flush, tx_push, rx_pop;
  assign tx_flush = reg_wr_en && sel_ctrl && reg_wdata[B_TXFL];
  assign rx_flush = reg_wr_en && sel_ctrl && reg_wdata[B_RXFL];
  assign tx_push  = reg_wr_en && sel_data;
  assign rx_pop   = reg_rd_en && sel_data;

  // queues
  logic [DATA_W-1:0] tx_head, rx_head;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;
  logic tx_full, tx_empty, tx_push_acc, tx_pop_acc;
  logic rx_full, rx_empty, rx_push_acc, rx_pop_acc;

  spi_fic_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) i_tx_fifo (
    .clk(clk), .rst_n(rst_n), .flush_i(tx_flush), .push_i(tx_push),
    .pop_i(tx_take), .wdata_i(reg_wdata), .head_o(tx_head), .level_o(tx_lvl),
    .full_o(tx_full), .empty_o(tx_empty), .push_acc_o(tx_push_acc),
    .pop_acc_o(tx_pop_acc)
  );

  spi_fic_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) i_rx_fifo (
    .clk(clk), .rst_n(rst_n), .flush_i(rx_flush), .push_i(rx_valid),
    .pop_i(rx_pop), .wdata_i(rx_word), .head_o(rx_head), .level_o(rx_lvl),
    .full_o(rx_full), .empty_o(rx_empty), .push_acc_o(rx_push_acc),
    .pop_acc_o(rx_pop_acc)
  );

  assign tx_word  = tx_head;
  assign tx_valid = !tx_empty;

  // configuration registers
  flag_vec_t        ie_q, ie_d;
  logic [THR_W-1:0] rxthr_q, rxthr_d, txthr_q, txthr_d;
  logic             ie_en, ctrl_en;

  assign ie_en   = reg_wr_en && sel_ie;
  assign ctrl_en = reg_wr_en && sel_ctrl;

  always_comb begin
    ie_d    = {reg_wdata[B_TCMP], reg_wdata[B_RCMP], reg_wdata[B_OVR]};
    rxthr_d = reg_wdata[B_RXTHR +: THR_W];
    txthr_d = reg_wdata[B_TXTHR +: THR_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
    end else if (ie_en) begin
      ie_q <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxthr_q <= '0;
      txthr_q <= '0;
    end else if (ctrl_en) begin
      rxthr_q <= rxthr_d;
      txthr_q <= txthr_d;
    end
  end

  // flag events
  logic ovr_set, rcmp_set, tcmp_set, rx_ready;
  assign ovr_set  = rx_valid && rx_full && !rx_pop_acc;
  assign rcmp_set = rx_push_acc && !rx_pop_acc && !rx_flush &&
                    ((CMP_W'(rx_lvl) + CMP_W'(1)) == CMP_W'(rxthr_q));
  assign tcmp_set = tx_pop_acc && !tx_push_acc && !tx_flush &&
                    (CMP_W'(tx_lvl) == (CMP_W'(txthr_q) + CMP_W'(1)));
  assign rx_ready = (rxthr_q != '0) && (CMP_W'(rx_lvl) >= CMP_W'(rxthr_q));

  flag_vec_t flags, set_vec, clr_mask;
  assign set_vec  = {tcmp_set, rcmp_set, ovr_set};
  assign clr_mask = {reg_wdata[B_TCMP], reg_wdata[B_RCMP], reg_wdata[B_OVR]};

  spi_fic_irq i_irq (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec),
    .clr_en_i(reg_wr_en && sel_istat), .clr_mask_i(clr_mask),
    .en_i(ie_q), .flags_o(flags), .irq_o(irq)
  );

  // read path
  logic [31:0] rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (sel_ie) begin
      rdata_d[B_OVR]  = ie_q[0];
      rdata_d[B_RCMP] = ie_q[1];
      rdata_d[B_TCMP] = ie_q[2];
    end
    if (sel_stat) begin
      rdata_d[B_RXNE]          = !rx_empty;
      rdata_d[B_TXLVL +: LVL_W] = tx_lvl;
      rdata_d[B_RXLVL +: LVL_W] = rx_lvl;
    end
    if (sel_istat) begin
      rdata_d[B_OVR]  = flags[0];
      rdata_d[B_RCMP] = flags[1];
      rdata_d[B_TCMP] = flags[2];
      rdata_d[B_RRDY] = rx_ready;
    end
    if (sel_ctrl) begin
      rdata_d[B_RXTHR +: THR_W] = rxthr_q;
      rdata_d[B_TXTHR +: THR_W] = txthr_q;
    end
    if (sel_data && !rx_empty) rdata_d = rx_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (reg_rd_en) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;

  assert_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !rx_pop) |=> flags[0]);
  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && sel_data && rx_empty) |=> (reg_rdata == '0));
  assert_rcmp_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags[1]) && $stable(rxthr_q)) |-> (CMP_W'(rx_lvl) >= CMP_W'(rxthr_q)));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rdata));
endmodule

// File: tb/test_spi_fifo_irq_ctrl.sv
module test_spi_fifo_irq_ctrl;
  localparam time CLK_PERIOD = 10;
  localparam logic [4:0] A_IE = 5'h00, A_STAT = 5'h04, A_ISTAT = 5'h08,
                         A_CTRL = 5'h0C, A_DATA = 5'h10;

  logic clk, rst_n, reg_wr_en, reg_rd_en, tx_valid, tx_take, rx_valid, irq;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, tx_word, rx_word;

  spi_fifo_irq_ctrl i_spi_fifo_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .tx_word(tx_word), .tx_valid(tx_valid), .tx_take(tx_take),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model
  logic [31:0] m_txq[$];
  logic [31:0] m_rxq[$];
  logic [2:0]  m_ie;
  logic        m_ovr, m_rcmp, m_tcmp;
  logic [3:0]  m_rxthr, m_txthr;
  logic [31:0] m_rdata, rdv;
  int          old_rx, old_tx;
  bit          rpop, tpop, tpush, rpush, rfl, tfl, ovr_e, rc_e, tc_e;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_txq.delete(); m_rxq.delete();
      m_ie = '0; m_ovr = 0; m_rcmp = 0; m_tcmp = 0;
      m_rxthr = '0; m_txthr = '0; m_rdata = '0;
    end else begin
      old_rx = m_rxq.size();
      old_tx = m_txq.size();
      rpop = reg_rd_en && reg_addr == A_DATA && old_rx > 0;
      rdv = '0;
      case (reg_addr)
        A_IE:    begin rdv[0] = m_ie[0]; rdv[3] = m_ie[1]; rdv[4] = m_ie[2]; end
        A_STAT:  begin rdv[0] = old_rx > 0; rdv[11:8] = 4'(old_tx); rdv[19:16] = 4'(old_rx); end
        A_ISTAT: begin rdv[0] = m_ovr; rdv[3] = m_rcmp; rdv[4] = m_tcmp;
                       rdv[9] = (m_rxthr != 0) && (old_rx >= int'(m_rxthr)); end
        A_CTRL:  begin rdv[3:0] = m_rxthr; rdv[11:8] = m_txthr; end
        A_DATA:  rdv = rpop ? m_rxq[0] : 32'h0;
        default: rdv = '0;
      endcase
      if (reg_rd_en) m_rdata = rdv;
      rfl = reg_wr_en && reg_addr == A_CTRL && reg_wdata[4];
      tfl = reg_wr_en && reg_addr == A_CTRL && reg_wdata[12];
      // receive side
      if (rpop) void'(m_rxq.pop_front());
      rpush = rx_valid && (old_rx < 8 || rpop);
      ovr_e = rx_valid && !rpush;
      if (rpush) m_rxq.push_back(rx_word);
      rc_e = rpush && !rpop && !rfl && (m_rxthr != 0) &&
             (old_rx < int'(m_rxthr)) && (old_rx + 1 >= int'(m_rxthr));
      if (rfl) m_rxq.delete();
      // transmit side
      tpop = tx_take && old_tx > 0;
      if (tpop) void'(m_txq.pop_front());
      tpush = reg_wr_en && reg_addr == A_DATA && (old_tx < 8 || tpop);
      if (tpush) m_txq.push_back(reg_wdata);
      tc_e = tpop && !tpush && !tfl && (old_tx == int'(m_txthr) + 1);
      if (tfl) m_txq.delete();
      // flags
      if (reg_wr_en && reg_addr == A_ISTAT) begin
        if (reg_wdata[0]) m_ovr = 0;
        if (reg_wdata[3]) m_rcmp = 0;
        if (reg_wdata[4]) m_tcmp = 0;
      end
      if (ovr_e) m_ovr = 1;
      if (rc_e)  m_rcmp = 1;
      if (tc_e)  m_tcmp = 1;
      if (reg_wr_en && reg_addr == A_IE) m_ie = {reg_wdata[4], reg_wdata[3], reg_wdata[0]};
      if (reg_wr_en && reg_addr == A_CTRL) begin
        m_rxthr = reg_wdata[3:0];
        m_txthr = reg_wdata[11:8];
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 irq vs model", {31'b0, irq},
            {31'b0, |({m_tcmp, m_rcmp, m_ovr} & m_ie)});
      check("R2 tx_valid vs model", {31'b0, tx_valid}, {31'b0, m_txq.size() > 0});
      if (m_txq.size() > 0) check("R2 tx_word vs model", tx_word, m_txq[0]);
      check("R11 reg_rdata vs model", reg_rdata, m_rdata);
    end
  end

  task automatic op(input logic wr, input logic rd, input logic [4:0] a,
                    input logic [31:0] d, input logic rv, input logic [31:0] rw,
                    input logic tk);
    @(posedge clk); #2;
    reg_wr_en = wr; reg_rd_en = rd; reg_addr = a; reg_wdata = d;
    rx_valid = rv; rx_word = rw; tx_take = tk;
    @(posedge clk); #1;
    reg_wr_en = 0; reg_rd_en = 0; reg_addr = '0; reg_wdata = '0;
    rx_valid = 0; rx_word = '0; tx_take = 0;
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    op(1, 0, a, d, 0, '0, 0);
  endtask

  task automatic rchk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    op(0, 1, a, '0, 0, '0, 0);
    check(tag, reg_rdata, exp);
  endtask

  task automatic eng_rx(input logic [31:0] w);
    op(0, 0, '0, '0, 1, w, 0);
  endtask

  task automatic eng_take();
    op(0, 0, '0, '0, 0, '0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_wr_en = 0; reg_rd_en = 0; reg_addr = '0; reg_wdata = '0;
    rx_valid = 0; rx_word = '0; tx_take = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset state
    @(negedge clk);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
    rchk(A_IE, 32'h0, "R1 enable reg");
    rchk(A_STAT, 32'h0, "R1 status reg");
    rchk(A_ISTAT, 32'h0, "R1 flag reg");
    rchk(A_CTRL, 32'h0, "R1 control reg");

    // R2/R5 transmit queue order
    wreg(A_DATA, 32'hA1); wreg(A_DATA, 32'hA2); wreg(A_DATA, 32'hA3);
    rchk(A_STAT, 32'h300, "R5 tx level 3");
    check("R2 head first", tx_word, 32'hA1);
    eng_take();
    check("R2 head after take", tx_word, 32'hA2);
    eng_take(); eng_take();
    check("R2 empty after drain", {31'b0, tx_valid}, 32'h0);
    rchk(A_ISTAT, 32'h10, "R8 tx complete at level 0");
    wreg(A_ISTAT, 32'h10);
    rchk(A_ISTAT, 32'h0, "R9 clear tx complete");

    // R2 full queue ignores writes
    for (int i = 0; i < 9; i++) wreg(A_DATA, 32'hB000_0000 + i);
    rchk(A_STAT, 32'h800, "R2 ninth write ignored");
    for (int i = 0; i < 8; i++) begin
      check("R2 drain order", tx_word, 32'hB000_0000 + i);
      eng_take();
    end
    check("R2 ninth word absent", {31'b0, tx_valid}, 32'h0);
    wreg(A_ISTAT, 32'h19);

    // R8/R10 transmit threshold crossing
    wreg(A_CTRL, 32'h200);
    wreg(A_IE, 32'h10);
    for (int i = 0; i < 4; i++) wreg(A_DATA, 32'hC0 + i);
    eng_take();
    check("R8 no flag above threshold", {31'b0, irq}, 32'h0);
    eng_take();
    check("R10 irq on tx complete", {31'b0, irq}, 32'h1);
    rchk(A_ISTAT, 32'h10, "R8 flag set at threshold");
    wreg(A_ISTAT, 32'h10);
    check("R9 irq drops after clear", {31'b0, irq}, 32'h0);
    eng_take(); eng_take();
    check("R8 no second set below threshold", {31'b0, irq}, 32'h0);

    // R7/R3 receive threshold and pops
    wreg(A_CTRL, 32'h003);
    eng_rx(32'hD0); eng_rx(32'hD1);
    rchk(A_ISTAT, 32'h0, "R7 below threshold");
    eng_rx(32'hD2);
    rchk(A_ISTAT, 32'h208, "R7 complete and ready");
    wreg(A_IE, 32'h08);
    check("R10 irq on rx complete", {31'b0, irq}, 32'h1);
    rchk(A_DATA, 32'hD0, "R3 pop first");
    rchk(A_ISTAT, 32'h008, "R7 ready follows level");
    rchk(A_DATA, 32'hD1, "R3 pop second");
    rchk(A_DATA, 32'hD2, "R3 pop third");
    rchk(A_DATA, 32'h0, "R3 empty read zero");
    rchk(A_STAT, 32'h0, "R3 empty read no change");
    wreg(A_ISTAT, 32'h08);
    check("R9 irq drops after rx clear", {31'b0, irq}, 32'h0);

    // R6 overrun
    wreg(A_CTRL, 32'h0);
    for (int i = 0; i < 8; i++) eng_rx(32'hE000_0000 + i);
    rchk(A_STAT, 32'h80001, "R5 rx level 8");
    wreg(A_IE, 32'h01);
    eng_rx(32'hDEAD);
    check("R6 irq on overrun", {31'b0, irq}, 32'h1);
    rchk(A_ISTAT, 32'h1, "R6 overrun flag");
    wreg(A_ISTAT, 32'h1);
    op(0, 1, A_DATA, '0, 1, 32'hF0, 0);
    check("R6 pop makes room", {31'b0, irq}, 32'h0);
    check("R3 pop with push", reg_rdata, 32'hE000_0000);
    for (int i = 1; i < 8; i++) rchk(A_DATA, 32'hE000_0000 + i, "R6 kept words");
    rchk(A_DATA, 32'hF0, "R6 word accepted with pop");
    rchk(A_DATA, 32'h0, "R6 dropped word absent");

    // R4 flush
    wreg(A_DATA, 32'h11); wreg(A_DATA, 32'h12); eng_rx(32'h21);
    rchk(A_STAT, 32'h10201, "R5 mixed levels");
    wreg(A_CTRL, 32'h1513);
    rchk(A_STAT, 32'h0, "R4 both flushed");
    rchk(A_CTRL, 32'h0503, "R4 flush bits read zero");
    op(1, 0, A_CTRL, 32'h10, 1, 32'h31, 0);
    rchk(A_STAT, 32'h0, "R4 flush beats push");

    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule